// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a serial peripheral interface master that software drives through a small 32-bit register window. Software first writes a transmit control word. That word picks one of four chip-select channels and can mark the next character as the last of a frame. Software then writes one data character of 8, 16, 24 or 32 bits. The controller shifts the character out most significant bit first, using the programmed clock polarity, clock phase and power-of-two clock divider. At the same time it captures the character arriving on the input line.

Each received character is stored together with the channel number and the end-of-frame marker of the character that produced it. The chosen chip select stays asserted across characters that lack the marker and is released after the character that carries it. A one-entry transmit buffer and a one-entry receive buffer separate software from the shifter. An interrupt-flag register reports buffer states and two sticky error conditions, and an enable mask combines those flags into one interrupt line.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the bit-rate register reads 1, the configuration register reads 0, the interrupt status reads 0x08, the interrupt enable reads 0, all chip selects are high, the serial clock is low and the interrupt line is low.
- R2: The registers sit at these offsets: configuration 0x40, status 0x44, bit rate 0x48, transmit control 0x4C, transmit data 0x50, receive control 0x54, receive data 0x58, interrupt status 0x68, interrupt enable 0x6C. Configuration bit 31 is enable, bit 14 is polarity, bit 13 is phase, bit 11 is master select and bits [1:0] are the length code. All other configuration bits read as zero.
- R3: Length code n gives 8·(n+1) bits per character. The character is sent most significant bit first on the output line. The received value is right-aligned in receive data, and its upper unused bits are zero.
- R4: The serial clock idles at the polarity bit. Each character produces exactly one clock pulse per bit. With phase 0 the input is sampled on the leading edge of each pulse; with phase 1 it is sampled on the trailing edge.
- R5: For a bit-rate value i, the serial clock changes level every 2^(i-1) bus clocks. A value of 0 behaves like 1.
- R6: At most one chip select is low at any time. The channel from transmit control bits [1:0] goes low before the first clock edge. It stays low after a character whose transmit control bit 2 was 0, and goes high after a character whose bit 2 was 1.
- R7: Receive control bits [1:0] and bit 2 return the channel and end-of-frame values of the character held in receive data.
- R8: Status bit 1 reads 1 while a character is waiting in the transmit buffer or being shifted, and 0 otherwise.
- R9: Interrupt status bit 3 is 1 while the transmit buffer is empty. Bit 2 becomes 1 only when a character completes, and a read of receive data clears it.
- R10: If a character completes while bit 2 is still set, interrupt status bit 6 sets and the newer character replaces the stored one. Bit 6 is sticky and is cleared by writing 1 to it.
- R11: A write to transmit data while the transmit buffer is full is dropped and sets interrupt status bit 7. Bit 7 is sticky and is cleared by writing 1 to it. Bits 5 and 4 always read 0.
- R12: While the enable bit is 0, no transfer starts and all chip selects stay high. A character already buffered starts once enable is set.
- R13: The interrupt line is the OR of the interrupt status bits masked by the interrupt enable register, and it appears one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Masked interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | CS_N | Active-low chip selects |

## Verification
The bench builds the controller with its default parameters: an 8-bit offset bus, four chip selects and a 3-bit divider field. With these values every divider setting is reachable, including the slowest half period of 64 bus clocks and the case where value 0 falls back to divide-by-2. All four length codes and all four channel numbers are also reachable. The input line is driven from the output line, either directly or inverted, so the bench knows each received value in advance. A bench-side sampler that follows the configured phase rebuilds the transmitted word and counts the clock edges of every polarity/phase mode.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam logic [7:0] OFF_CFG    = 8'h40;
  localparam logic [7:0] OFF_STAT   = 8'h44;
  localparam logic [7:0] OFF_RATE   = 8'h48;
  localparam logic [7:0] OFF_TXCTL  = 8'h4C;
  localparam logic [7:0] OFF_TXDAT  = 8'h50;
  localparam logic [7:0] OFF_RXCTL  = 8'h54;
  localparam logic [7:0] OFF_RXDAT  = 8'h58;
  localparam logic [7:0] OFF_ISTAT  = 8'h68;
  localparam logic [7:0] OFF_IEN    = 8'h6C;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_SHIFT,
    ENG_HOLD
  } eng_state_e;

  // character length in bits from the 2-bit length code
  function automatic logic [5:0] code_to_bits(input logic [1:0] code);
    return {3'(code) + 3'd1, 3'b000};
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  // half period of 2^(div-1) bus clocks, div 0 folds onto div 1
  always_comb begin
    if (div == '0) half_m1 = '0;
    else           half_m1 = (CNT_W'(1) << (div - DIV_W'(1))) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == half_m1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CS_N   = 4,
  localparam int CH_W  = $clog2(CS_N),
  localparam int LEN_W = $clog2(DATA_W) + 1,
  localparam int EDG_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [1:0]        len_code,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [CH_W-1:0]   chan,
  input  logic              eof,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic [CH_W-1:0]   rx_chan,
  output logic              rx_eof,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_N-1:0]   cs_n
);
  eng_state_e        state;
  logic [LEN_W-1:0]  nbits_q;
  logic [EDG_W-1:0]  edge_q;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] aligned;
  logic              cpha_q;
  logic              eof_q;
  logic [CH_W-1:0]   chan_q;
  logic [EDG_W-1:0]  last_edge;

  assign aligned   = tx_word << (DATA_W - int'(code_to_bits(len_code)));
  assign last_edge = {nbits_q, 1'b0} - EDG_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      nbits_q <= '0;
      edge_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      cpha_q  <= 1'b0;
      eof_q   <= 1'b0;
      chan_q  <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= '1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          sclk <= cpol;
          if (start) begin
            nbits_q <= LEN_W'(code_to_bits(len_code));
            edge_q  <= '0;
            rx_sh   <= '0;
            cpha_q  <= cpha;
            eof_q   <= eof;
            chan_q  <= chan;
            cs_n    <= ~(CS_N'(1) << chan);
            if (!cpha) begin
              mosi  <= aligned[DATA_W-1];
              tx_sh <= aligned << 1;
            end else begin
              tx_sh <= aligned;
            end
            state <= ENG_SETUP;
          end
        end
        ENG_SETUP: if (tick) state <= ENG_SHIFT;
        ENG_SHIFT: if (tick) begin
          sclk <= ~sclk;
          // even edge index is leading; phase picks which edge samples
          if (edge_q[0] == cpha_q) begin
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
          end else begin
            mosi  <= tx_sh[DATA_W-1];
            tx_sh <= tx_sh << 1;
          end
          if (edge_q == last_edge) state <= ENG_HOLD;
          else                     edge_q <= edge_q + EDG_W'(1);
        end
        ENG_HOLD: if (tick) begin
          if (eof_q) cs_n <= '1;
          done  <= 1'b1;
          state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy    = (state != ENG_IDLE);
  assign rx_word = rx_sh;
  assign rx_chan = chan_q;
  assign rx_eof  = eof_q;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CS_N   = 4,
  parameter int DIV_W  = 3,
  localparam int DATA_W = 32,
  localparam int CH_W   = $clog2(CS_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [CS_N-1:0]   spi_cs_n
);
  logic              cfg_en, cfg_cpol, cfg_cpha, cfg_master;
  logic [1:0]        cfg_len;
  logic [DIV_W-1:0]  rate_q;
  logic [CH_W-1:0]   txc_chan;
  logic              txc_eof;
  logic              tx_full;
  logic [DATA_W-1:0] tx_data_q;
  logic [CH_W-1:0]   tx_chan_q;
  logic              tx_eof_q;
  logic              rx_full;
  logic [DATA_W-1:0] rx_data_q;
  logic [CH_W-1:0]   rx_chan_q;
  logic              rx_eof_q;
  logic              err_txc, err_rxo;
  logic [7:0]        ien_q;
  logic [7:0]        istat;

  logic              wr_acc, rd_acc, wr_txd, rd_rx, start;
  logic              eng_busy, eng_done, tick;
  logic [DATA_W-1:0] eng_rx;
  logic [CH_W-1:0]   eng_chan;
  logic              eng_eof;

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;
  assign wr_txd = wr_acc && (bus_addr == ADDR_W'(OFF_TXDAT));
  assign rd_rx  = rd_acc && (bus_addr == ADDR_W'(OFF_RXDAT));
  assign start  = tx_full & ~eng_busy & cfg_en;
  assign istat  = {err_txc, err_rxo, 2'b00, ~tx_full, rx_full, 2'b00};

  spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst(rst), .run(eng_busy), .div(rate_q), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W), .CS_N(CS_N)) u_eng (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_data_q),
    .len_code(cfg_len), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .chan(tx_chan_q), .eof(tx_eof_q), .tick(tick), .miso(spi_miso),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
    .rx_chan(eng_chan), .rx_eof(eng_eof),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en <= 1'b0; cfg_cpol <= 1'b0; cfg_cpha <= 1'b0; cfg_master <= 1'b0;
      cfg_len   <= '0;
      rate_q    <= DIV_W'(1);
      txc_chan  <= '0;
      txc_eof   <= 1'b0;
      tx_full   <= 1'b0;
      tx_data_q <= '0;
      tx_chan_q <= '0;
      tx_eof_q  <= 1'b0;
      rx_full   <= 1'b0;
      rx_data_q <= '0;
      rx_chan_q <= '0;
      rx_eof_q  <= 1'b0;
      err_txc   <= 1'b0;
      err_rxo   <= 1'b0;
      ien_q     <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_acc) begin
        case (bus_addr)
          ADDR_W'(OFF_CFG): begin
            cfg_en     <= bus_wdata[31];
            cfg_cpol   <= bus_wdata[14];
            cfg_cpha   <= bus_wdata[13];
            cfg_master <= bus_wdata[11];
            cfg_len    <= bus_wdata[1:0];
          end
          ADDR_W'(OFF_RATE):  rate_q <= bus_wdata[DIV_W-1:0];
          ADDR_W'(OFF_TXCTL): begin
            txc_chan <= bus_wdata[CH_W-1:0];
            txc_eof  <= bus_wdata[2];
          end
          ADDR_W'(OFF_ISTAT): begin
            if (bus_wdata[7]) err_txc <= 1'b0;
            if (bus_wdata[6]) err_rxo <= 1'b0;
          end
          ADDR_W'(OFF_IEN):   ien_q <= bus_wdata[7:0];
          default: ;
        endcase
      end
      // transmit buffer: a busy buffer drops the write and flags it
      if (start) tx_full <= 1'b0;
      if (wr_txd) begin
        if (tx_full) begin
          err_txc <= 1'b1;
        end else begin
          tx_full   <= 1'b1;
          tx_data_q <= bus_wdata;
          tx_chan_q <= txc_chan;
          tx_eof_q  <= txc_eof;
        end
      end
      // receive buffer: newest character wins, overwrite is flagged
      if (eng_done) begin
        rx_full   <= 1'b1;
        rx_data_q <= eng_rx;
        rx_chan_q <= eng_chan;
        rx_eof_q  <= eng_eof;
        if (rx_full && !rd_rx) err_rxo <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
      irq <= |(istat & ien_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      case (bus_addr)
        ADDR_W'(OFF_CFG):   bus_rdata <= {cfg_en, 16'b0, cfg_cpol, cfg_cpha, 1'b0,
                                          cfg_master, 9'b0, cfg_len};
        ADDR_W'(OFF_STAT):  bus_rdata <= {30'b0, eng_busy | tx_full, 1'b0};
        ADDR_W'(OFF_RATE):  bus_rdata <= DATA_W'(rate_q);
        ADDR_W'(OFF_TXCTL): bus_rdata <= DATA_W'({txc_eof, txc_chan});
        ADDR_W'(OFF_TXDAT): bus_rdata <= '0;
        ADDR_W'(OFF_RXCTL): bus_rdata <= DATA_W'({rx_eof_q, rx_chan_q});
        ADDR_W'(OFF_RXDAT): bus_rdata <= rx_data_q;
        ADDR_W'(OFF_ISTAT): bus_rdata <= DATA_W'(istat);
        ADDR_W'(OFF_IEN):   bus_rdata <= DATA_W'(ien_q);
        default:            bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_host_ctrl_checker.sv
module spi_host_ctrl_checker #(
  parameter int CS_N = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [CS_N-1:0] cs_n,
  input logic            sclk,
  input logic            cpol,
  input logic            cfg_en,
  input logic            eng_busy,
  input logic            eng_done,
  input logic            rx_full,
  input logic            rd_rx,
  input logic            err_rxo,
  input logic            wr_txd,
  input logic            tx_full,
  input logic            err_txc
);
  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // clock moves only inside a frame, apart from following a polarity change
  assert_sclk_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sclk) && ($past(cpol) == $past(cpol, 2))) |-> (cs_n != '1));

  assert_rx_from_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(eng_done));

  assert_rx_overrun_R10: assert property (@(posedge clk) disable iff (rst)
    (eng_done && rx_full && !rd_rx) |=> err_rxo);

  assert_tx_collide_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_txd && tx_full) |=> err_txc);

  assert_no_start_off_R12: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !eng_busy) |=> !eng_busy);
endmodule

bind spi_host_ctrl spi_host_ctrl_checker #(.CS_N(CS_N)) u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .cpol(cfg_cpol),
  .cfg_en(cfg_en), .eng_busy(eng_busy), .eng_done(eng_done),
  .rx_full(rx_full), .rd_rx(rd_rx), .err_rxo(err_rxo),
  .wr_txd(wr_txd), .tx_full(tx_full), .err_txc(err_txc)
);

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;
  logic        inv = 1'b1;

  int tests = 0, fails = 0;
  int cyc = 0, toggles = 0, last_t = 0, last_gap = 0, cap_cnt = 0;
  logic [31:0] cap_sh = '0;
  logic prev_sclk = 1'b0;
  logic tb_cpol = 1'b0, tb_cpha = 1'b0;

  always #10 clk = ~clk;

  assign spi_miso = inv ? ~spi_mosi : spi_mosi;

  spi_host_ctrl u_spi_host_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // sampler on the far side of the link, away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_sclk <= spi_sclk;
    if (!rst && spi_sclk != prev_sclk) begin
      toggles  <= toggles + 1;
      last_gap <= cyc - last_t;
      last_t   <= cyc;
      if ((spi_sclk != tb_cpol) == !tb_cpha) begin
        cap_sh  <= {cap_sh[30:0], spi_mosi};
        cap_cnt <= cap_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(8'h44, s);
      if (s[1] == 1'b0) return;
    end
    chk(1'b0, "R8 idle timeout", s, 0);
  endtask

  task automatic set_cfg(input bit en, input bit cpol, input bit cpha,
                         input logic [1:0] len);
    wr(8'h40, {en, 16'b0, cpol, cpha, 1'b0, 1'b1, 9'b0, len});
    tb_cpol = cpol; tb_cpha = cpha;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] lmask(input logic [1:0] len);
    return (len == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (len + 1))) - 1);
  endfunction

  task automatic xfer(input logic [1:0] ch, input bit eof, input logic [31:0] d,
                      output logic [31:0] rxd, output logic [31:0] rxc);
    wr(8'h4C, {29'b0, eof, ch});
    wr(8'h50, d);
    wait_idle();
    rd(8'h54, rxc);
    rd(8'h58, rxd);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h48, v); chk(v == 1, "R1 rate reset", v, 1);
    rd(8'h40, v); chk(v == 0, "R1 cfg reset", v, 0);
    rd(8'h68, v); chk(v == 32'h08, "R1 istat reset", v, 32'h08);
    rd(8'h6C, v); chk(v == 0, "R1 ien reset", v, 0);
    chk(spi_cs_n == 4'hF && spi_sclk == 0 && irq == 0, "R1 pins reset",
        {spi_cs_n, spi_sclk, irq}, {4'hF, 2'b00});
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk(v == 32'h8000_6803, "R2 cfg fields", v, 32'h8000_6803);
    wr(8'h48, 32'h5);
    rd(8'h48, v); chk(v == 32'h5, "R2 rate offset", v, 32'h5);
    wr(8'h4C, 32'h6);
    rd(8'h4C, v); chk(v == 32'h6, "R2 txctl offset", v, 32'h6);
    wr(8'h40, 32'h0);
    wr(8'h48, 32'h1);
    wr(8'h4C, 32'h0);
  endtask

  task automatic t_modes();
    logic [31:0] rxd, rxc;
    int t0, c0;
    for (int m = 0; m < 4; m++) begin
      set_cfg(1'b1, m[1], m[0], 2'd0);
      t0 = toggles; c0 = cap_cnt;
      xfer(2'd0, 1'b1, 32'h0000_00A5, rxd, rxc);
      chk(toggles - t0 == 16, "R4 edge count", toggles - t0, 16);
      chk(cap_cnt - c0 == 8 && cap_sh[7:0] == 8'hA5, "R3 mosi msb first",
          cap_sh[7:0], 8'hA5);
      chk(rxd == 32'h5A, "R4 sampled data", rxd, 32'h5A);
      chk(spi_sclk == m[1], "R4 idle level", spi_sclk, m[1]);
    end
  endtask

  task automatic t_lengths();
    logic [31:0] rxd, rxc, m;
    for (int l = 1; l < 4; l++) begin
      set_cfg(1'b1, 1'b0, 1'b0, 2'(l));
      m = lmask(2'(l));
      xfer(2'd1, 1'b1, 32'hDEAD_BEEF, rxd, rxc);
      chk((cap_sh & m) == (32'hDEAD_BEEF & m), "R3 tx length",
          cap_sh & m, 32'hDEAD_BEEF & m);
      chk(rxd == (~32'hDEAD_BEEF & m), "R3 rx right aligned", rxd,
          ~32'hDEAD_BEEF & m);
    end
  endtask

  task automatic t_rate();
    logic [31:0] rxd, rxc;
    int exp;
    set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
    for (int i = 0; i < 8; i += 3) begin
      wr(8'h48, 32'(i));
      xfer(2'd0, 1'b1, 32'h3C, rxd, rxc);
      exp = (i == 0) ? 1 : (1 << (i - 1));
      chk(last_gap == exp, "R5 half period", last_gap, exp);
    end
    wr(8'h48, 32'h1);
  endtask

  task automatic t_frame();
    logic [31:0] rxd, rxc;
    set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
    xfer(2'd2, 1'b0, 32'h11, rxd, rxc);
    chk(spi_cs_n == 4'b1011, "R6 cs held in frame", spi_cs_n, 4'b1011);
    chk(rxc == 32'h2, "R7 rx ctl no eof", rxc, 32'h2);
    xfer(2'd2, 1'b1, 32'h22, rxd, rxc);
    chk(spi_cs_n == 4'hF, "R6 cs released", spi_cs_n, 4'hF);
    chk(rxc == 32'h6, "R7 rx ctl eof", rxc, 32'h6);
    xfer(2'd3, 1'b1, 32'h33, rxd, rxc);
    chk(rxc == 32'h7, "R7 rx ctl ch3", rxc, 32'h7);
  endtask

  task automatic t_busy_flags();
    logic [31:0] v;
    wr(8'h48, 32'h7);
    wr(8'h4C, 32'h4);
    wr(8'h50, 32'h81);
    rd(8'h44, v); chk(v == 32'h2, "R8 busy while shifting", v, 32'h2);
    rd(8'h68, v); chk(v[3:2] == 2'b10, "R9 tx free rx empty", v[3:2], 2'b10);
    wait_idle();
    rd(8'h44, v); chk(v == 0, "R8 idle", v, 0);
    rd(8'h68, v); chk(v[2] == 1, "R9 rx ready", v, 32'hC);
    rd(8'h58, v); chk(v == 32'h7E, "R9 rx data", v, 32'h7E);
    rd(8'h68, v); chk(v == 32'h08, "R9 read clears", v, 32'h08);
    wr(8'h48, 32'h1);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    wr(8'h6C, 32'h40);
    wr(8'h4C, 32'h4);
    wr(8'h50, 32'h0F); wait_idle();
    wr(8'h50, 32'hF0); wait_idle();
    rd(8'h68, v); chk(v == 32'h4C, "R10 overrun set", v, 32'h4C);
    chk(irq == 1'b1, "R13 irq on masked flag", irq, 1);
    rd(8'h58, v); chk(v == 32'h0F, "R10 newer kept", v, 32'h0F);
    wr(8'h68, 32'h40);
    rd(8'h68, v); chk(v == 32'h08, "R10 w1c", v, 32'h08);
    chk(irq == 1'b0, "R13 irq cleared", irq, 0);
    wr(8'h6C, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(8'h48, 32'h7);
    wr(8'h50, 32'h01);
    wr(8'h50, 32'h02);
    wr(8'h50, 32'h03);
    rd(8'h68, v); chk(v[7] == 1 && v[3] == 0 && v[5:4] == 0, "R11 collision",
                      v, 32'h80);
    wait_idle();
    rd(8'h58, v); chk(v == 32'hFD, "R11 second kept", v, 32'hFD);
    wr(8'h68, 32'hC0);
    rd(8'h68, v); chk(v == 32'h08, "R11 w1c", v, 32'h08);
    wr(8'h48, 32'h1);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    set_cfg(1'b0, 1'b0, 1'b0, 2'd0);
    wr(8'h50, 32'h55);
    repeat (100) @(negedge clk);
    chk(spi_cs_n == 4'hF, "R12 no select while off", spi_cs_n, 4'hF);
    rd(8'h68, v); chk(v == 32'h0, "R12 held in buffer", v, 0);
    set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
    wait_idle();
    rd(8'h58, v); chk(v == 32'hAA, "R12 starts when enabled", v, 32'hAA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg();
    t_modes();
    t_lengths();
    t_rate();
    t_frame();
    t_busy_flags();
    t_overrun();
    t_collide();
    t_enable();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule